// File: doc/BRIEF.md
# Interrupt Gate Privilege and Frame Sequencer

This block settles the entry of an interrupt or trap through an interrupt gate or a trap gate in a segmented protected-mode processor. The caller has already fetched the gate, the target code-segment descriptor and the new stack selector and descriptor. It presents their decoded fields on `start_i`, together with the current privilege level, the virtual-8086 flag and the register values that may have to be saved.

In the cycle of acceptance the block runs the gate checks in a fixed priority. It then does one of three things. It raises a one-cycle fault report made of a vector and an error code. It raises a one-cycle unrecoverable indication. Or it starts streaming the stack frame one word per handshake. While the frame streams, the block also presents the frame size in bytes, the updated flags, whether the privilege level changes, and whether the data segment registers must be loaded with null. A new event can be accepted in the same cycle as the last word's handshake.

Top module: `intr_gate_seq`

## Requirements
- R1: The updated flags equal the old flags with bits 8, 14, 16 and 17 cleared. Bit 9 is also cleared for an interrupt gate (`gate_intr_i`=1) and is kept for a trap gate.
- R2: The checks on the code segment come first. A system segment, a data segment, or a DPL above CPL each raise vector 13. The error code is `gate_sel_i` with bits 1:0 cleared, plus 1 when `ext_i` is set.
- R3: A target that passes R2 but is not present raises vector 11, with the same error code as R2.
- R4: The privilege-change path is taken when the target is non-conforming and its DPL is below CPL. The frame size is 10 bytes, or 12 with an error code. Add 8 when `vm_i` is set. Double the result for a 32-bit gate.
- R5: On the privilege-change path with `vm_i` set, a target DPL other than 0 raises vector 13 with the R2 error code.
- R6: On the privilege-change path, the following raise vector 10: a stack selector RPL (bits 1:0) that differs from the target DPL, a stack DPL that differs from the target DPL, or a stack segment that is not a writable data segment. A not-present stack segment raises vector 12. In both cases the error code is `ss_sel_i` with bits 1:0 cleared, plus 1 when `ext_i` is set.
- R7: On the same-privilege path, `vm_i` set raises vector 13 with the R2 error code. Otherwise the frame size is 6 bytes, or 8 with an error code, doubled for a 32-bit gate.
- R8: A gate offset above the target limit raises vector 13 with error code 0. This check comes after every other check of its path.
- R9: The privilege-change frame is pushed in this order: GS, FS, DS, ES (only when `vm_i` is set, which also sets `null_segs_o`), then SS, SP, flags, CS, IP, and the error code if there is one.
- R10: The same-privilege frame is pushed in this order: flags, CS, IP, and the error code if there is one. `priv_change_o` is 0 for this path.
- R11: A 16-bit gate that passes every check on the privilege-change path with `vm_i` set pulses `fatal_o` and produces no fault and no frame.
- R12: For a 16-bit gate, every pushed word carries the low 16 bits of its value, with the upper bits zero.
- R13: Each event yields exactly one outcome: a fault, a fatal indication or a frame. When several checks fail, the first one in the order R2, R3, R5, R6, R8 is reported.
- R14: A word that is not accepted stays on `push_data_o` with `push_valid_o` held. `ready_o` is high when the block is idle, or when the last word is being accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Event presented; taken when ready_o is high |
| ready_o | output | 1 | Block can take an event this cycle |
| ext_i | input | 1 | Event is an external interrupt |
| gate_intr_i | input | 1 | 1 interrupt gate, 0 trap gate |
| gate_32_i | input | 1 | Gate is 32-bit |
| gate_sel_i | input | 16 | Target code selector from the gate |
| gate_off_i | input | 32 | Target offset from the gate |
| has_err_i | input | 1 | Event carries an error code |
| err_code_i | input | 32 | Error code to push |
| cpl_i | input | 2 | Current privilege level |
| vm_i | input | 1 | Event arrives from virtual-8086 mode |
| cs_sys_i | input | 1 | Target descriptor is a system segment |
| cs_code_i | input | 1 | Target descriptor is a code segment |
| cs_conf_i | input | 1 | Target code segment is conforming |
| cs_dpl_i | input | 2 | Target DPL |
| cs_present_i | input | 1 | Target present |
| cs_limit_i | input | 32 | Target limit |
| ss_sel_i | input | 16 | New stack selector |
| ss_sys_i | input | 1 | Stack descriptor is a system segment |
| ss_code_i | input | 1 | Stack descriptor is a code segment |
| ss_writable_i | input | 1 | Stack data segment is writable |
| ss_dpl_i | input | 2 | Stack DPL |
| ss_present_i | input | 1 | Stack segment present |
| old_gs_i | input | 16 | GS to save |
| old_fs_i | input | 16 | FS to save |
| old_ds_i | input | 16 | DS to save |
| old_es_i | input | 16 | ES to save |
| old_ss_i | input | 16 | SS to save |
| old_sp_i | input | 32 | Stack pointer to save |
| old_flags_i | input | 32 | Flags to save and update |
| old_cs_i | input | 16 | CS to save |
| old_ip_i | input | 32 | Instruction pointer to save |
| fault_valid_o | output | 1 | One-cycle fault report |
| fault_vec_o | output | 8 | Fault vector (10, 11, 12 or 13) |
| fault_code_o | output | 16 | Fault error code |
| fatal_o | output | 1 | One-cycle unrecoverable indication |
| push_valid_o | output | 1 | Frame word valid |
| push_ready_i | input | 1 | Consumer takes the frame word |
| push_data_o | output | 32 | Frame word |
| push_last_o | output | 1 | Word is the last of the frame |
| frame_size_o | output | 6 | Frame size in bytes, valid with push_valid_o |
| new_flags_o | output | 32 | Updated flags, valid with push_valid_o |
| priv_change_o | output | 1 | Privilege-change path taken |
| null_segs_o | output | 1 | Load GS, FS, DS and ES with null |

## Verification
Two things can happen in the same cycle: the handshake of a frame's last word and the acceptance of the next event. The bench holds `push_ready_i` high. In the cycle where `push_last_o` shows, it raises `start_i` with a new, different event. It requires `ready_o` to be high at that point. On the following cycle it requires the first word of the new frame, together with the new frame's size and flags. A stall with `push_ready_i` low is also applied, and during it the word and `ready_o` are checked to stay unchanged.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;
  typedef enum logic [7:0] {
    VEC_TS = 8'd10,
    VEC_NP = 8'd11,
    VEC_SS = 8'd12,
    VEC_GP = 8'd13
  } fault_vec_e;

  localparam int FLAG_TF = 8;
  localparam int FLAG_IF = 9;
  localparam int FLAG_NT = 14;
  localparam int FLAG_RF = 16;
  localparam int FLAG_VM = 17;
endpackage

// File: rtl/gate_check.sv
module gate_check
  import intr_gate_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int OFF_W = 32
) (
  input  logic             ext_i,
  input  logic             gate_32_i,
  input  logic [SEL_W-1:0] gate_sel_i,
  input  logic [OFF_W-1:0] gate_off_i,
  input  logic [1:0]       cpl_i,
  input  logic             vm_i,
  input  logic             cs_sys_i,
  input  logic             cs_code_i,
  input  logic             cs_conf_i,
  input  logic [1:0]       cs_dpl_i,
  input  logic             cs_present_i,
  input  logic [OFF_W-1:0] cs_limit_i,
  input  logic [SEL_W-1:0] ss_sel_i,
  input  logic             ss_sys_i,
  input  logic             ss_code_i,
  input  logic             ss_writable_i,
  input  logic [1:0]       ss_dpl_i,
  input  logic             ss_present_i,
  output logic             fault_o,
  output fault_vec_e       vec_o,
  output logic [SEL_W-1:0] code_o,
  output logic             fatal_o,
  output logic             inter_o
);
  logic [SEL_W-1:0] cs_code, ss_code;
  logic             over_limit;

  assign cs_code    = {gate_sel_i[SEL_W-1:2], 2'b00} + SEL_W'(ext_i);
  assign ss_code    = {ss_sel_i[SEL_W-1:2], 2'b00} + SEL_W'(ext_i);
  assign over_limit = gate_off_i > cs_limit_i;
  assign inter_o    = !cs_conf_i && (cs_dpl_i < cpl_i);

  // first failing check wins
  always_comb begin
    fault_o = 1'b0;
    vec_o   = VEC_GP;
    code_o  = '0;
    fatal_o = 1'b0;
    if (cs_sys_i || !cs_code_i || (cs_dpl_i > cpl_i)) begin
      fault_o = 1'b1; code_o = cs_code;
    end else if (!cs_present_i) begin
      fault_o = 1'b1; vec_o = VEC_NP; code_o = cs_code;
    end else if (inter_o) begin
      if (vm_i && cs_dpl_i != 2'd0) begin
        fault_o = 1'b1; code_o = cs_code;
      end else if ((ss_sel_i[1:0] != cs_dpl_i) || (ss_dpl_i != cs_dpl_i) ||
                   ss_sys_i || ss_code_i || !ss_writable_i) begin
        fault_o = 1'b1; vec_o = VEC_TS; code_o = ss_code;
      end else if (!ss_present_i) begin
        fault_o = 1'b1; vec_o = VEC_SS; code_o = ss_code;
      end else if (over_limit) begin
        fault_o = 1'b1;
      end else begin
        fatal_o = vm_i && !gate_32_i;
      end
    end else begin
      if (vm_i || (!cs_conf_i && cs_dpl_i != cpl_i)) begin
        fault_o = 1'b1; code_o = cs_code;
      end else if (over_limit) begin
        fault_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (fault_o) assert (!fatal_o) else $error("AST_FAULT_XOR_FATAL"); // R13
  end
endmodule

// File: rtl/frame_builder.sv
module frame_builder #(
  parameter int DW   = 32,
  parameter int SW16 = 16,
  parameter int N    = 10,
  parameter int CW   = $clog2(N + 1),
  parameter int SZW  = $clog2(N * DW / 8 + 1)
) (
  input  logic            inter_i,
  input  logic            vm_i,
  input  logic            g32_i,
  input  logic            has_err_i,
  input  logic [DW-1:0]   err_i,
  input  logic [SW16-1:0] gs_i,
  input  logic [SW16-1:0] fs_i,
  input  logic [SW16-1:0] ds_i,
  input  logic [SW16-1:0] es_i,
  input  logic [SW16-1:0] ss_i,
  input  logic [DW-1:0]   sp_i,
  input  logic [DW-1:0]   flags_i,
  input  logic [SW16-1:0] cs_i,
  input  logic [DW-1:0]   ip_i,
  output logic [DW-1:0]   words_o [N],
  output logic [CW-1:0]   count_o,
  output logic [SZW-1:0]  size_o
);
  localparam logic [DW-1:0] HALF_MASK = {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
  logic [DW-1:0] raw [N];
  logic [CW-1:0] n;

  always_comb begin
    for (int i = 0; i < N; i++) raw[i] = '0;
    n = '0;
    if (inter_i && vm_i) begin
      raw[0] = DW'(gs_i); raw[1] = DW'(fs_i);
      raw[2] = DW'(ds_i); raw[3] = DW'(es_i);
      n = CW'(4);
    end
    if (inter_i) begin
      raw[n] = DW'(ss_i); raw[CW'(n + 1)] = sp_i;
      n = CW'(n + 2);
    end
    raw[n] = flags_i; raw[CW'(n + 1)] = DW'(cs_i); raw[CW'(n + 2)] = ip_i;
    n = CW'(n + 3);
    if (has_err_i) begin
      raw[n] = err_i;
      n = CW'(n + 1);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign words_o[g] = g32_i ? raw[g] : (raw[g] & HALF_MASK);
  end

  assign count_o = n;
  assign size_o  = SZW'(n) * (g32_i ? SZW'(DW / 8) : SZW'(DW / 16));
endmodule

// File: rtl/push_stream.sv
module push_stream #(
  parameter int DW = 32,
  parameter int N  = 10,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] words_i [N],
  input  logic [CW-1:0] count_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  logic [DW-1:0] mem_q [N];
  logic [CW-1:0] idx_q, cnt_q;
  logic          busy_q;

  assign valid_o = busy_q;
  assign data_o  = mem_q[idx_q];
  assign last_o  = busy_q && (idx_q == CW'(cnt_q - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= count_i;
      for (int i = 0; i < N; i++) mem_q[i] <= words_i[i];
    end else if (busy_q && ready_i) begin
      if (last_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + 1'b1;
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o)) else $error("AST_HOLD_WORD"); // R14
  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o) else $error("AST_LAST_VALID"); // R14
endmodule

// File: rtl/intr_gate_seq.sv
module intr_gate_seq
  import intr_gate_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 16,
  parameter int MAX_WORDS = 10,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int SIZE_W   = $clog2(MAX_WORDS * DATA_W / 8 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              ready_o,
  input  logic              ext_i,
  input  logic              gate_intr_i,
  input  logic              gate_32_i,
  input  logic [SEL_W-1:0]  gate_sel_i,
  input  logic [DATA_W-1:0] gate_off_i,
  input  logic              has_err_i,
  input  logic [DATA_W-1:0] err_code_i,
  input  logic [1:0]        cpl_i,
  input  logic              vm_i,
  input  logic              cs_sys_i,
  input  logic              cs_code_i,
  input  logic              cs_conf_i,
  input  logic [1:0]        cs_dpl_i,
  input  logic              cs_present_i,
  input  logic [DATA_W-1:0] cs_limit_i,
  input  logic [SEL_W-1:0]  ss_sel_i,
  input  logic              ss_sys_i,
  input  logic              ss_code_i,
  input  logic              ss_writable_i,
  input  logic [1:0]        ss_dpl_i,
  input  logic              ss_present_i,
  input  logic [SEL_W-1:0]  old_gs_i,
  input  logic [SEL_W-1:0]  old_fs_i,
  input  logic [SEL_W-1:0]  old_ds_i,
  input  logic [SEL_W-1:0]  old_es_i,
  input  logic [SEL_W-1:0]  old_ss_i,
  input  logic [DATA_W-1:0] old_sp_i,
  input  logic [DATA_W-1:0] old_flags_i,
  input  logic [SEL_W-1:0]  old_cs_i,
  input  logic [DATA_W-1:0] old_ip_i,
  output logic              fault_valid_o,
  output logic [7:0]        fault_vec_o,
  output logic [SEL_W-1:0]  fault_code_o,
  output logic              fatal_o,
  output logic              push_valid_o,
  input  logic              push_ready_i,
  output logic [DATA_W-1:0] push_data_o,
  output logic              push_last_o,
  output logic [SIZE_W-1:0] frame_size_o,
  output logic [DATA_W-1:0] new_flags_o,
  output logic              priv_change_o,
  output logic              null_segs_o
);
  logic             chk_fault, chk_fatal, chk_inter;
  fault_vec_e       chk_vec;
  logic [SEL_W-1:0] chk_code;
  logic [DATA_W-1:0] fb_words [MAX_WORDS];
  logic [CNT_W-1:0]  fb_count;
  logic [SIZE_W-1:0] fb_size;
  logic [DATA_W-1:0] flag_clr;
  logic              accept, load;
  logic              g32_q;

  gate_check #(.SEL_W(SEL_W), .OFF_W(DATA_W)) u_check (
    .ext_i, .gate_32_i, .gate_sel_i, .gate_off_i, .cpl_i, .vm_i,
    .cs_sys_i, .cs_code_i, .cs_conf_i, .cs_dpl_i, .cs_present_i, .cs_limit_i,
    .ss_sel_i, .ss_sys_i, .ss_code_i, .ss_writable_i, .ss_dpl_i, .ss_present_i,
    .fault_o(chk_fault), .vec_o(chk_vec), .code_o(chk_code),
    .fatal_o(chk_fatal), .inter_o(chk_inter)
  );

  frame_builder #(.DW(DATA_W), .SW16(SEL_W), .N(MAX_WORDS), .CW(CNT_W), .SZW(SIZE_W)) u_frame (
    .inter_i(chk_inter), .vm_i, .g32_i(gate_32_i), .has_err_i, .err_i(err_code_i),
    .gs_i(old_gs_i), .fs_i(old_fs_i), .ds_i(old_ds_i), .es_i(old_es_i),
    .ss_i(old_ss_i), .sp_i(old_sp_i), .flags_i(old_flags_i), .cs_i(old_cs_i),
    .ip_i(old_ip_i), .words_o(fb_words), .count_o(fb_count), .size_o(fb_size)
  );

  assign ready_o = !push_valid_o || (push_last_o && push_ready_i);
  assign accept  = start_i && ready_o;
  assign load    = accept && !chk_fault && !chk_fatal;

  push_stream #(.DW(DATA_W), .N(MAX_WORDS), .CW(CNT_W)) u_stream (
    .clk_i, .rst_ni, .load_i(load), .words_i(fb_words), .count_i(fb_count),
    .valid_o(push_valid_o), .ready_i(push_ready_i), .data_o(push_data_o),
    .last_o(push_last_o)
  );

  always_comb begin
    flag_clr = '0;
    flag_clr[FLAG_TF] = 1'b1;
    flag_clr[FLAG_NT] = 1'b1;
    flag_clr[FLAG_RF] = 1'b1;
    flag_clr[FLAG_VM] = 1'b1;
    flag_clr[FLAG_IF] = gate_intr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_valid_o <= 1'b0;
      fault_vec_o   <= '0;
      fault_code_o  <= '0;
      fatal_o       <= 1'b0;
      frame_size_o  <= '0;
      new_flags_o   <= '0;
      priv_change_o <= 1'b0;
      null_segs_o   <= 1'b0;
      g32_q         <= 1'b0;
    end else begin
      fault_valid_o <= accept && chk_fault;
      fatal_o       <= accept && chk_fatal;
      if (accept && chk_fault) begin
        fault_vec_o  <= chk_vec;
        fault_code_o <= chk_code;
      end
      if (load) begin
        frame_size_o  <= fb_size;
        new_flags_o   <= old_flags_i & ~flag_clr;
        priv_change_o <= chk_inter;
        null_segs_o   <= chk_inter && vm_i;
        g32_q         <= gate_32_i;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_o || fatal_o) |-> !push_valid_o) else $error("AST_ONE_OUTCOME"); // R13
  AST_HALF_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_o && !g32_q |-> push_data_o[DATA_W-1:DATA_W/2] == '0) else $error("AST_HALF_WORD"); // R12
  AST_FLAGS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_o |-> !new_flags_o[FLAG_TF] && !new_flags_o[FLAG_NT] &&
                     !new_flags_o[FLAG_RF] && !new_flags_o[FLAG_VM]) else $error("AST_FLAGS_CLEARED"); // R1
  AST_NULL_ONLY_INTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_o && null_segs_o |-> priv_change_o) else $error("AST_NULL_ONLY_INTER"); // R9
endmodule

// File: tb/sim_intr_gate_seq.sv
module sim_intr_gate_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start, ready, ext, gintr, g32, has_err, vm;
  logic [15:0] gsel, ss_sel, o_gs, o_fs, o_ds, o_es, o_ss, o_cs;
  logic [31:0] goff, errc, cs_lim, o_sp, o_fl, o_ip;
  logic [1:0] cpl, cs_dpl, ss_dpl;
  logic cs_sys, cs_code, cs_conf, cs_pres, ss_sys, ss_code, ss_wr, ss_pres;
  logic fv, fat, pv, pr, pl, pc, ns;
  logic [7:0] fvec;
  logic [15:0] fcode;
  logic [31:0] pd, nfl;
  logic [5:0] fsz;

  intr_gate_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ready_o(ready), .ext_i(ext),
    .gate_intr_i(gintr), .gate_32_i(g32), .gate_sel_i(gsel), .gate_off_i(goff),
    .has_err_i(has_err), .err_code_i(errc), .cpl_i(cpl), .vm_i(vm),
    .cs_sys_i(cs_sys), .cs_code_i(cs_code), .cs_conf_i(cs_conf), .cs_dpl_i(cs_dpl),
    .cs_present_i(cs_pres), .cs_limit_i(cs_lim), .ss_sel_i(ss_sel), .ss_sys_i(ss_sys),
    .ss_code_i(ss_code), .ss_writable_i(ss_wr), .ss_dpl_i(ss_dpl), .ss_present_i(ss_pres),
    .old_gs_i(o_gs), .old_fs_i(o_fs), .old_ds_i(o_ds), .old_es_i(o_es), .old_ss_i(o_ss),
    .old_sp_i(o_sp), .old_flags_i(o_fl), .old_cs_i(o_cs), .old_ip_i(o_ip),
    .fault_valid_o(fv), .fault_vec_o(fvec), .fault_code_o(fcode), .fatal_o(fat),
    .push_valid_o(pv), .push_ready_i(pr), .push_data_o(pd), .push_last_o(pl),
    .frame_size_o(fsz), .new_flags_o(nfl), .priv_change_o(pc), .null_segs_o(ns)
  );

  int checks = 0, errors = 0;
  logic [31:0] exp_w [10];
  logic [31:0] got_w [12];
  int got_n;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic defaults();
    start = 0; ext = 0; gintr = 1; g32 = 1; has_err = 0; vm = 0;
    gsel = 16'h0008; goff = 32'h100; errc = 32'hABCD_1234;
    cpl = 2'd3; cs_sys = 0; cs_code = 1; cs_conf = 0; cs_dpl = 0; cs_pres = 1;
    cs_lim = 32'hFFFF; ss_sel = 16'h0010; ss_sys = 0; ss_code = 0; ss_wr = 1;
    ss_dpl = 0; ss_pres = 1;
    o_gs = 16'h1111; o_fs = 16'h2222; o_ds = 16'h3333; o_es = 16'h4444;
    o_ss = 16'h5555; o_sp = 32'h6666_0FF0; o_fl = 32'h0003_4302;
    o_cs = 16'h7777; o_ip = 32'h8888_1234; pr = 1;
  endtask

  // drive at negedge, accept at posedge, sample at following negedge
  task automatic fire();
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
  endtask

  task automatic collect();
    got_n = 0;
    pr = 1;
    while (pv && got_n < 12) begin
      got_w[got_n] = pd;
      got_n++;
      if (pl) begin
        @(posedge clk); @(negedge clk);
        break;
      end
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic expect_fault(input string req, input logic [7:0] v, input logic [15:0] c);
    fire();
    chk({req, " fault_valid"}, 32'(fv), 32'd1);
    chk({req, " vector"}, 32'(fvec), 32'(v));
    chk({req, " code"}, 32'(fcode), 32'(c));
    chk({req, " no frame"}, 32'(pv), 32'd0);
    @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input int n, input logic [5:0] sz,
                              input logic [31:0] flags, input logic inter, input logic nul);
    fire();
    chk({req, " no fault"}, 32'(fv | fat), 32'd0);
    chk({req, " size"}, 32'(fsz), 32'(sz));
    chk({req, " flags"}, nfl, flags);
    chk({req, " priv"}, 32'(pc), 32'(inter));
    chk({req, " null"}, 32'(ns), 32'(nul));
    collect();
    chk({req, " count"}, 32'(got_n), 32'(n));
    for (int i = 0; i < n && i < got_n; i++) chk({req, " word"}, got_w[i], exp_w[i]);
  endtask

  task automatic t_reset();
    chk("R14 reset ready", 32'(ready), 32'd1);
    chk("R13 reset valid", 32'(pv | fv | fat), 32'd0);
  endtask

  task automatic t_inter32();  // R1 R4 R9
    defaults();
    exp_w[0] = 32'h5555; exp_w[1] = o_sp; exp_w[2] = o_fl; exp_w[3] = 32'h7777; exp_w[4] = o_ip;
    expect_frame("R4 R9 R1 inter32", 5, 6'd20, 32'h0000_0002, 1, 0);
  endtask

  task automatic t_inter16_trap();  // R1 R4 R12
    defaults(); g32 = 0; gintr = 0; has_err = 1;
    exp_w[0] = 32'h5555; exp_w[1] = 32'h0FF0; exp_w[2] = 32'h4302; exp_w[3] = 32'h7777;
    exp_w[4] = 32'h1234; exp_w[5] = 32'h1234;
    expect_frame("R12 R4 R1 inter16 trap", 6, 6'd12, 32'h0000_0202, 1, 0);
  endtask

  task automatic t_vm32();  // R9 R4
    defaults(); vm = 1;
    exp_w[0] = 32'h1111; exp_w[1] = 32'h2222; exp_w[2] = 32'h3333; exp_w[3] = 32'h4444;
    exp_w[4] = 32'h5555; exp_w[5] = o_sp; exp_w[6] = o_fl; exp_w[7] = 32'h7777; exp_w[8] = o_ip;
    expect_frame("R9 R4 vm32", 9, 6'd36, 32'h0000_0002, 1, 1);
  endtask

  task automatic t_same16_err();  // R7 R10
    defaults(); cpl = 0; g32 = 0; has_err = 1;
    exp_w[0] = 32'h4302; exp_w[1] = 32'h7777; exp_w[2] = 32'h1234; exp_w[3] = 32'h1234;
    expect_frame("R7 R10 same16 err", 4, 6'd8, 32'h0000_0002, 0, 0);
  endtask

  task automatic t_same_conf32();  // R7 R10: conforming target stays on same path
    defaults(); cs_conf = 1;
    exp_w[0] = o_fl; exp_w[1] = 32'h7777; exp_w[2] = o_ip;
    expect_frame("R7 R10 conforming", 3, 6'd12, 32'h0000_0002, 0, 0);
  endtask

  task automatic t_cs_faults();  // R2 R3
    defaults(); gsel = 16'h000B; ext = 1; cs_sys = 1;
    expect_fault("R2 system seg", 8'd13, 16'h0009);
    defaults(); gsel = 16'h000B; cs_code = 0;
    expect_fault("R2 data seg", 8'd13, 16'h0008);
    defaults(); cpl = 1; cs_dpl = 2;
    expect_fault("R2 dpl>cpl", 8'd13, 16'h0008);
    defaults(); cs_pres = 0; ext = 1;
    expect_fault("R3 not present", 8'd11, 16'h0009);
  endtask

  task automatic t_vm_dpl();  // R5
    defaults(); vm = 1; cs_dpl = 1; ss_sel = 16'h0011; ss_dpl = 1;
    expect_fault("R5 vm dpl", 8'd13, 16'h0008);
  endtask

  task automatic t_stack_faults();  // R6
    defaults(); ss_sel = 16'h0023;
    expect_fault("R6 ss rpl", 8'd10, 16'h0020);
    defaults(); ss_dpl = 1; ext = 1;
    expect_fault("R6 ss dpl", 8'd10, 16'h0011);
    defaults(); ss_wr = 0;
    expect_fault("R6 ss readonly", 8'd10, 16'h0010);
    defaults(); ss_code = 1;
    expect_fault("R6 ss code", 8'd10, 16'h0010);
    defaults(); ss_pres = 0;
    expect_fault("R6 ss absent", 8'd12, 16'h0010);
  endtask

  task automatic t_same_vm();  // R7
    defaults(); cpl = 0; vm = 1;
    expect_fault("R7 same vm", 8'd13, 16'h0008);
  endtask

  task automatic t_limit();  // R8 R13
    defaults(); goff = 32'h1_0000;
    expect_fault("R8 limit inter", 8'd13, 16'h0000);
    defaults(); cpl = 0; goff = 32'h1_0000;
    expect_fault("R8 limit same", 8'd13, 16'h0000);
    defaults(); goff = 32'h1_0000; ss_pres = 0;
    expect_fault("R13 stack before limit", 8'd12, 16'h0010);
    defaults(); goff = 32'h1_0000; cs_sys = 1; ss_wr = 0;
    expect_fault("R13 cs before others", 8'd13, 16'h0008);
  endtask

  task automatic t_fatal();  // R11
    defaults(); vm = 1; g32 = 0;
    fire();
    chk("R11 fatal", 32'(fat), 32'd1);
    chk("R11 no fault", 32'(fv), 32'd0);
    chk("R11 no frame", 32'(pv), 32'd0);
    @(negedge clk);
  endtask

  task automatic t_stall_and_chain();  // R14
    defaults(); cpl = 0;
    fire();
    pr = 0;
    chk("R14 stall ready low", 32'(ready), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R14 stall hold valid", 32'(pv), 32'd1);
    chk("R14 stall hold data", pd, o_fl);
    pr = 1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R14 at last", 32'(pl), 32'd1);
    chk("R14 ready on last", 32'(ready), 32'd1);
    // next event in the same cycle as the last handshake
    cpl = 3; g32 = 0; gintr = 0;
    fire();
    chk("R14 chained valid", 32'(pv), 32'd1);
    chk("R14 chained first word", pd, 32'h5555);
    chk("R14 chained size", 32'(fsz), 32'd10);
    chk("R14 chained flags", nfl, 32'h0000_0202);
    collect();
    chk("R14 chained count", 32'(got_n), 32'd5);
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_inter32();
    t_inter16_trap();
    t_vm32();
    t_same16_err();
    t_same_conf32();
    t_cs_faults();
    t_vm_dpl();
    t_stack_faults();
    t_same_vm();
    t_limit();
    t_fatal();
    t_stall_and_chain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule